// File: doc/BRIEF.md
# Cell-Polarity Classifier and Stress Writer

This block collects per-row error counts from two retention passes over a memory array: one pass in which every row held all zeros and one in which every row held all ones. For every row it keeps which passes have reported and whether each reported pass saw errors. From these two results it derives a 2-bit cell-polarity class. The class tells whether the row's storage capacitors hold charge for a stored one (true cells), for a stored zero (anti cells), for both (mixed), or whether neither pass showed errors (clean). A table read port returns the class of any row.

On a start pulse the block checks that every row has both results. It then walks the rows in ascending order and issues one row-write command per row on a valid/ready command port. Each write carries the solid pattern that keeps that row's capacitors charged. After the last write it issues one command that turns automatic refresh back on with a refresh-command interval of one clock cycle. If any row still lacks a result when the start is taken, no command is issued and a sticky error flag is raised.

Result beats arrive on a valid/ready stream. A beat transfers on a clock edge where both valid and ready are high. Ready is held low for the whole stress phase, so the source must keep its beat stable and wait. The command port follows the same rule in the other direction. While the command consumer holds ready low, the block keeps valid, kind, row and data unchanged.

Top module: `polarity_stress_ctrl`

## Requirements
- R1: A row with both results has class {zeros-pass error, ones-pass error}, where a pass counts as an error when its count is nonzero: 2'b01 true cell (errors only with all ones), 2'b10 anti cell (errors only with all zeros), 2'b11 mixed, 2'b00 clean.
- R2: The table read port returns, one clock after `rd_row` is sampled, `rd_known`=1 and the class when both results of that row are present. Otherwise it returns `rd_known`=0 and `rd_class`=2'b00.
- R3: A later result for the same row and pass replaces the earlier one.
- R4: `res_ready` is high exactly while no stress phase is in progress (`stress_busy` low). A beat is taken on an edge where `res_valid` and `res_ready` are both high.
- R5: After an accepted start with every row classified, row-write commands (`cmd_kind`=0) are issued once per row for rows 0 to ROWS-1 in ascending order. `cmd_data` is all zeros for class 2'b10 and all ones for classes 2'b01, 2'b11 and 2'b00.
- R6: After the last row write is taken, exactly one refresh-enable command (`cmd_kind`=1) is issued with `cmd_data` equal to 1, the one-cycle interval.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_kind`, `cmd_row` and `cmd_data` hold their values into the next cycle.
- R8: A start taken while any row lacks either result issues no command. It sets `incomplete_err`, which stays high until reset.
- R9: `stress_done` rises when the refresh-enable command is taken and stays high until the next accepted start. A start pulse while `stress_busy` is high is ignored.
- R10: A result beat taken in the same cycle as an accepted start counts toward the completeness check of that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Result beat valid |
| res_ready | output | 1 | Result beat ready (low during stress) |
| res_pass_ones | input | 1 | 1: beat is from the all-ones pass, 0: from the all-zeros pass |
| res_row | input | ROW_W | Row the beat refers to |
| res_count | input | CNT_W | Error count of that row in that pass |
| stress_start | input | 1 | Start pulse for the stress phase |
| stress_busy | output | 1 | Stress phase in progress |
| stress_done | output | 1 | Stress phase finished |
| incomplete_err | output | 1 | Sticky: start taken with an unclassified row |
| cmd_valid | output | 1 | Memory command valid |
| cmd_ready | input | 1 | Memory command ready |
| cmd_kind | output | 1 | 0: row write, 1: enable automatic refresh |
| cmd_row | output | ROW_W | Target row of a row write |
| cmd_data | output | DATA_W | Row pattern, or refresh interval in cycles |
| rd_row | input | ROW_W | Table read address |
| rd_class | output | 2 | Class of the addressed row |
| rd_known | output | 1 | Addressed row has both results |

## Verification
Two functions can fall in the same cycle: the final result beat that completes the table, and the start pulse whose completeness check depends on it. The bench drives the last missing all-zeros result and the start pulse on the same clock edge. It then judges the outcome at the ports: the full ascending write sequence and the refresh-enable command must follow, and the error flag must not change from its earlier value. A second overlap, a start pulse during an active stress walk, is injected mid-sequence and must leave the row order untouched.

// File: rtl/cpw_pkg.sv
`timescale 1ns/1ps
package cpw_pkg;
  // Class code: bit1 = all-zeros pass saw errors, bit0 = all-ones pass saw errors
  typedef enum logic [1:0] {
    CLS_CLEAN = 2'b00,
    CLS_TRUE  = 2'b01,
    CLS_ANTI  = 2'b10,
    CLS_MIXED = 2'b11
  } cell_class_e;

  typedef enum logic {
    CMD_ROW_WRITE  = 1'b0,
    CMD_REFRESH_ON = 1'b1
  } cmd_kind_e;

  typedef struct packed {
    logic seen_z;
    logic seen_o;
    logic err_z;
    logic err_o;
  } row_entry_t;

  localparam int REFI_MIN = 1;

  function automatic logic [1:0] class_of(input row_entry_t e);
    if (e.seen_z && e.seen_o) return {e.err_z, e.err_o};
    return CLS_CLEAN;
  endfunction
endpackage

// File: rtl/pol_row_table.sv
`timescale 1ns/1ps
module pol_row_table
  import cpw_pkg::*;
#(
  parameter int ROWS  = 64,
  parameter int ROW_W = $clog2(ROWS),
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_ones,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [ROW_W-1:0] rd_row,
  output logic [1:0]       rd_class,
  output logic             rd_known,
  input  logic [ROW_W-1:0] seq_row,
  output logic [1:0]       seq_class,
  output logic             all_known
);
  localparam int KW = $clog2(ROWS + 1);

  row_entry_t ent [ROWS];
  logic       wr_ok;
  logic       wr_err;
  row_entry_t cur;
  logic       completes;
  logic [KW-1:0] known_cnt;

  assign wr_ok  = wr_en && (int'(wr_row) < ROWS);
  assign wr_err = |wr_count;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    row_entry_t ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (wr_ok && (wr_row == ROW_W'(g))) begin
        if (wr_ones) begin
          ent_q.seen_o <= 1'b1;
          ent_q.err_o  <= wr_err;
        end else begin
          ent_q.seen_z <= 1'b1;
          ent_q.err_z  <= wr_err;
        end
      end
    end
    assign ent[g] = ent_q;
  end

  assign cur       = wr_ok ? ent[wr_row] : '0;
  assign completes = wr_ok && !(cur.seen_z && cur.seen_o) &&
                     (wr_ones ? cur.seen_z : cur.seen_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) known_cnt <= '0;
    else if (completes) known_cnt <= known_cnt + KW'(1);
  end

  assign all_known = (known_cnt == KW'(ROWS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_class <= CLS_CLEAN;
      rd_known <= 1'b0;
    end else if (int'(rd_row) < ROWS) begin
      rd_class <= class_of(ent[rd_row]);
      rd_known <= ent[rd_row].seen_z && ent[rd_row].seen_o;
    end else begin
      rd_class <= CLS_CLEAN;
      rd_known <= 1'b0;
    end
  end

  assign seq_class = (int'(seq_row) < ROWS) ? class_of(ent[seq_row]) : CLS_CLEAN;
endmodule

// File: rtl/pol_pattern_map.sv
`timescale 1ns/1ps
module pol_pattern_map
  import cpw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        cls,
  output logic [DATA_W-1:0] pattern
);
  // Anti cells hold charge for a stored zero; every other class is stressed with ones.
  always_comb begin
    if (cls == CLS_ANTI) pattern = '0;
    else                 pattern = '1;
  end
endmodule

// File: rtl/pol_stress_seq.sv
`timescale 1ns/1ps
module pol_stress_seq
  import cpw_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int ROW_W  = $clog2(ROWS),
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              all_known,
  input  logic [DATA_W-1:0] row_pattern,
  output logic [ROW_W-1:0]  seq_row,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_kind,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic              incomplete_err
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WRITE, S_REFRESH} st_e;
  st_e              st;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      row_q          <= '0;
      done           <= 1'b0;
      incomplete_err <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st   <= S_CHECK;
          done <= 1'b0;
        end
        S_CHECK: if (all_known) begin
          st    <= S_WRITE;
          row_q <= '0;
        end else begin
          incomplete_err <= 1'b1;
          st             <= S_IDLE;
        end
        S_WRITE: if (cmd_ready) begin
          if (row_q == LAST_ROW) st <= S_REFRESH;
          else                   row_q <= row_q + ROW_W'(1);
        end
        S_REFRESH: if (cmd_ready) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign seq_row   = row_q;
  assign busy      = (st != S_IDLE);
  assign cmd_valid = (st == S_WRITE) || (st == S_REFRESH);
  assign cmd_kind  = (st == S_REFRESH) ? CMD_REFRESH_ON : CMD_ROW_WRITE;
  assign cmd_row   = row_q;
  assign cmd_data  = (st == S_REFRESH) ? DATA_W'(REFI_MIN) :
                     (st == S_WRITE)   ? row_pattern : '0;
endmodule

// File: rtl/polarity_stress_ctrl.sv
`timescale 1ns/1ps
module polarity_stress_ctrl
  import cpw_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 64,
  parameter int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic              res_pass_ones,
  input  logic [ROW_W-1:0]  res_row,
  input  logic [CNT_W-1:0]  res_count,
  input  logic              stress_start,
  output logic              stress_busy,
  output logic              stress_done,
  output logic              incomplete_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_kind,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [DATA_W-1:0] cmd_data,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [1:0]        rd_class,
  output logic              rd_known
);
  logic [ROW_W-1:0]  seq_row;
  logic [1:0]        seq_class;
  logic [DATA_W-1:0] row_pattern;
  logic              all_known;
  logic              take;

  assign res_ready = !stress_busy;
  assign take      = res_valid && res_ready;

  pol_row_table #(.ROWS(ROWS), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (take),
    .wr_ones  (res_pass_ones),
    .wr_row   (res_row),
    .wr_count (res_count),
    .rd_row   (rd_row),
    .rd_class (rd_class),
    .rd_known (rd_known),
    .seq_row  (seq_row),
    .seq_class(seq_class),
    .all_known(all_known)
  );

  pol_pattern_map #(.DATA_W(DATA_W)) u_map (
    .cls    (seq_class),
    .pattern(row_pattern)
  );

  pol_stress_seq #(.ROWS(ROWS), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (stress_start),
    .all_known     (all_known),
    .row_pattern   (row_pattern),
    .seq_row       (seq_row),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_kind      (cmd_kind),
    .cmd_row       (cmd_row),
    .cmd_data      (cmd_data),
    .busy          (stress_busy),
    .done          (stress_done),
    .incomplete_err(incomplete_err)
  );
endmodule

// File: rtl/polarity_stress_chk.sv
`timescale 1ns/1ps
module polarity_stress_chk #(
  parameter int ROWS   = 64,
  parameter int DATA_W = 64,
  parameter int ROW_W  = $clog2(ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_ready,
  input logic              stress_busy,
  input logic              stress_done,
  input logic              incomplete_err,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_kind,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [DATA_W-1:0] cmd_data
);
  p_ready_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready == !stress_busy);

  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) &&
                                $stable(cmd_row) && $stable(cmd_data));

  p_refresh_interval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind |-> cmd_data == DATA_W'(1));

  p_solid_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_kind |-> (cmd_data == '0) || (cmd_data == '1));

  p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_kind && cmd_ready && (cmd_row != ROW_W'(ROWS - 1))
      |=> cmd_valid && !cmd_kind && (cmd_row == $past(cmd_row) + ROW_W'(1)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    incomplete_err |=> incomplete_err);

  p_cmd_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> stress_busy);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stress_done |-> !stress_busy);
endmodule

bind polarity_stress_ctrl polarity_stress_chk #(.ROWS(ROWS), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .res_ready     (res_ready),
  .stress_busy   (stress_busy),
  .stress_done   (stress_done),
  .incomplete_err(incomplete_err),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_kind      (cmd_kind),
  .cmd_row       (cmd_row),
  .cmd_data      (cmd_data)
);

// File: tb/sim_polarity_stress_ctrl.sv
`timescale 1ns/1ps
module sim_polarity_stress_ctrl;
  localparam int ROWS   = 64;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 64;
  localparam int ROW_W  = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0, res_pass_ones = 1'b0;
  logic [ROW_W-1:0] res_row = '0;
  logic [CNT_W-1:0] res_count = '0;
  logic stress_start = 1'b0, cmd_ready = 1'b0;
  logic [ROW_W-1:0] rd_row = '0;
  logic res_ready, stress_busy, stress_done, incomplete_err;
  logic cmd_valid, cmd_kind, rd_known;
  logic [ROW_W-1:0] cmd_row;
  logic [DATA_W-1:0] cmd_data;
  logic [1:0] rd_class;

  int n_tests = 0, n_fail = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  polarity_stress_ctrl #(.ROWS(ROWS), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .res_valid(res_valid), .res_ready(res_ready), .res_pass_ones(res_pass_ones),
    .res_row(res_row), .res_count(res_count),
    .stress_start(stress_start), .stress_busy(stress_busy), .stress_done(stress_done),
    .incomplete_err(incomplete_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_row(cmd_row), .cmd_data(cmd_data),
    .rd_row(rd_row), .rd_class(rd_class), .rd_known(rd_known));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Final expected class of a row: bit1 = zeros-pass error, bit0 = ones-pass error
  function automatic logic [1:0] exp_cls(input int r);
    return {r[1], r[0]};
  endfunction

  task automatic send(input bit ones, input int row, input int cnt);
    @(negedge clk);
    res_valid = 1'b1; res_pass_ones = ones; res_row = ROW_W'(row); res_count = CNT_W'(cnt);
    #1;
    while (!res_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic read_row(input int row, input bit exp_known, input logic [1:0] exp_c, input string req);
    @(negedge clk);
    rd_row = ROW_W'(row);
    @(negedge clk);
    check(rd_known == exp_known, req, rd_known, exp_known);
    check(rd_class == exp_c, req, rd_class, exp_c);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_ready && !stress_busy && !stress_done, "R4 reset idle", {res_ready, stress_busy, stress_done}, 3'b100);
    check(!incomplete_err && !cmd_valid, "R8 reset flags", {incomplete_err, cmd_valid}, 0);
    check(!rd_known, "R2 reset read", rd_known, 0);
  endtask

  task automatic t_fill_partial();
    for (int r = 0; r < ROWS; r++) send(1'b1, r, (r == 7) ? 0 : (r[0] ? (r % 7) + 1 : 0));
    for (int r = 0; r < ROWS; r++) if (r != 5) send(1'b0, r, r[1] ? (r % 5) + 1 : 0);
    read_row(5, 1'b0, 2'b00, "R2 unknown row");
    read_row(7, 1'b1, 2'b10, "R1 anti cell");
    read_row(1, 1'b1, 2'b01, "R1 true cell");
    read_row(4, 1'b1, 2'b00, "R1 clean");
  endtask

  task automatic t_incomplete_start();
    bit saw = 0;
    @(negedge clk); stress_start = 1'b1;
    @(negedge clk); stress_start = 1'b0;
    repeat (6) begin
      cmd_ready = 1'b1;
      @(negedge clk);
      if (cmd_valid) saw = 1;
    end
    check(!saw, "R8 no command when incomplete", saw, 0);
    check(incomplete_err, "R8 flag set", incomplete_err, 1);
    check(!stress_busy && !stress_done, "R9 idle after reject", {stress_busy, stress_done}, 0);
  endtask

  task automatic t_overwrite();
    send(1'b1, 7, 5);
    read_row(7, 1'b1, 2'b11, "R3 replaced result gives mixed");
  endtask

  task automatic t_same_cycle_and_stress();
    int exp_row = 0;
    bit got_ref = 0, stall = 0, ready_bad = 0;
    logic [ROW_W-1:0] s_row; logic [DATA_W-1:0] s_data; logic s_kind;
    logic [DATA_W-1:0] pat;
    @(negedge clk);
    res_valid = 1'b1; res_pass_ones = 1'b0; res_row = ROW_W'(5); res_count = '0;
    stress_start = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; stress_start = 1'b0;
    for (int k = 0; k < 2000 && !got_ref; k++) begin
      @(negedge clk);
      stress_start = (k == 20);           // R9: start during busy must be ignored
      cmd_ready = ((k % 3) != 1);
      #1;
      if (stress_busy && res_ready) ready_bad = 1;
      if (stall) begin
        check(cmd_valid && cmd_row == s_row && cmd_data == s_data && cmd_kind == s_kind,
              "R7 held while stalled", cmd_row, s_row);
      end
      stall = cmd_valid && !cmd_ready;
      s_row = cmd_row; s_data = cmd_data; s_kind = cmd_kind;
      if (cmd_valid && cmd_ready) begin
        if (!cmd_kind) begin
          pat = (exp_cls(exp_row) == 2'b10) ? '0 : '1;
          check(int'(cmd_row) == exp_row, "R5 row order", cmd_row, exp_row);
          check(cmd_data == pat, "R5 pattern", cmd_data, pat);
          exp_row++;
        end else begin
          check(exp_row == ROWS, "R6 refresh after last write", exp_row, ROWS);
          check(cmd_data == DATA_W'(1), "R6 one-cycle interval", cmd_data, 1);
          got_ref = 1;
        end
      end
    end
    stress_start = 1'b0;
    check(got_ref, "R10 same-cycle beat completes table", got_ref, 1);
    check(!ready_bad, "R4 ready low during stress", ready_bad, 0);
    @(negedge clk);
    check(stress_done && !stress_busy, "R9 done after refresh", {stress_done, stress_busy}, 2'b10);
    check(!cmd_valid, "R6 single refresh command", cmd_valid, 0);
    check(incomplete_err, "R8 flag stays set", incomplete_err, 1);
    read_row(5, 1'b1, 2'b01, "R10 row completed by same-cycle beat");
    read_row(6, 1'b1, 2'b10, "R1 anti row after stress");
  endtask

  initial begin
    t_reset();
    t_fill_partial();
    t_incomplete_start();
    t_overwrite();
    t_same_cycle_and_stress();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end
endmodule